// File: doc/BRIEF.md
# Serial Divider Programming Register

This block takes divider settings for a frequency synthesizer over a three-wire serial link (serial clock, serial data, load strobe) and places them in parallel registers that drive the dividers. All three lines are brought into the system clock domain through flop synchronisers. The block samples data on each rising edge of the synchronised serial clock and shifts it in most-significant bit first. A rising edge on the synchronised strobe ends the frame. At that point the word is checked and sent to one of two destinations.

A word that ends in control bit 1 and is 16 bits long programs the reference side: a 14-bit reference ratio and a prescaler-select bit. A word that ends in control bit 0 and is 19 bits long programs the main side: a 7-bit swallow count and an 11-bit main count. Each destination raises its own one-cycle update pulse when it loads. A frame that is the wrong length, whose control bit does not match its length, or that carries an illegal ratio is dropped. A dropped frame leaves every register as it was and sets an error flag that stays set until reset.

Top module: `serial_div_prog`

## Requirements
- R1: On each rising edge of the synchronised serial clock, the synchronised data bit is shifted in. Bits arrive most-significant first, so the last bit before the strobe is bit 0 of the word.
- R2: The output registers change only on a rising strobe edge that carries a valid frame. Shifted bits without a strobe have no visible effect.
- R3: A frame of exactly 16 bits with bit 0 = 1 loads the reference ratio from bits 14..1 and the prescaler select from bit 15. It pulses the reference update output.
- R4: A frame of exactly 19 bits with bit 0 = 0 loads the swallow count from bits 7..1 and the main count from bits 18..8. It pulses the main update output. The reference register is not touched.
- R5: A strobe that ends a frame of any bit count other than 16 or 19 is rejected, and this includes zero bits. It loads nothing and sets the error flag.
- R6: A 16-bit frame with bit 0 = 0, or a 19-bit frame with bit 0 = 1, is rejected and sets the error flag.
- R7: A reference frame whose ratio is below 8 is rejected. Both reference outputs keep their values and the error flag is set. Ratios 8 and 16383 are accepted.
- R8: A main frame is rejected, and sets the error flag, if its main count is below 3 or below its swallow count. Both main outputs keep their values.
- R9: Once set, the error flag stays set until reset, even after later valid frames.
- R10: During and after reset, all parallel outputs, both update pulses and the error flag are 0.
- R11: The bit count restarts at every strobe, so the frame after a rejected frame is judged on its own bits.
- R12: Each update pulse lasts exactly one system clock cycle, and the two update pulses are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, most-significant bit first |
| ser_strobe | input | 1 | Load strobe; its rising edge ends a frame |
| r_div | output | 14 | Reference divider ratio |
| presc_sel | output | 1 | Prescaler select |
| n_div | output | 11 | Main counter value |
| a_div | output | 7 | Swallow counter value |
| r_upd | output | 1 | One-cycle pulse when the reference side loads |
| na_upd | output | 1 | One-cycle pulse when the main side loads |
| prog_err | output | 1 | Sticky flag for a rejected frame |

## Verification
Asymmetric values such as 100, 500 and 37 are written to each destination. This exposes a reversed bit order or a field shifted by one position. The legal-range edges (8 and 16383 for the reference ratio; 3/3, 2047/127 and 1000/0 for the main side) separate a correct bound from an off-by-one bound. Bits are shifted with the strobe held back to show that nothing loads before the strobe. Empty, 17-bit and 20-bit frames, frames whose length and control bit disagree, and out-of-range ratios are each checked against held outputs and a newly set error flag. A valid frame after a rejected one shows that the bit count restarts, and it also shows that the error flag survives a later good load.

// File: rtl/serial_div_prog_pkg.sv
package serial_div_prog_pkg;
   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_REF  = 2'd1,
      DST_MAIN = 2'd2
   } dst_e;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d_in;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter #(
   parameter int SR_W    = 19,
   parameter int CNT_W   = 5,
   parameter int CNT_MAX = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             bit_val,
   input  logic             frame_end,
   output logic [SR_W-1:0]  shift_q,
   output logic [CNT_W-1:0] count_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         count_q <= '0;
      end else if (frame_end) begin
         count_q <= '0;
      end else if (bit_en) begin
         shift_q <= {shift_q[SR_W-2:0], bit_val};
         if (count_q != CNT_W'(CNT_MAX)) count_q <= count_q + 1'b1;
      end
   end
endmodule

// File: rtl/sprog_decode.sv
module sprog_decode
   import serial_div_prog_pkg::*;
#(
   parameter int R_W    = 14,
   parameter int N_W    = 11,
   parameter int A_W    = 7,
   parameter int R_MIN  = 8,
   parameter int N_MIN  = 3,
   parameter int SR_W   = 19,
   parameter int CNT_W  = 5
) (
   input  logic [SR_W-1:0]  shift_q,
   input  logic [CNT_W-1:0] count_q,
   input  logic             frame_end,
   output dst_e             dst,
   output logic             reject,
   output logic [R_W-1:0]   f_r,
   output logic             f_p,
   output logic [N_W-1:0]   f_n,
   output logic [A_W-1:0]   f_a
);
   localparam int REF_LEN  = R_W + 2;
   localparam int MAIN_LEN = N_W + A_W + 1;

   logic ctrl, len_ref, len_main, r_ok, na_ok;

   assign ctrl     = shift_q[0];
   assign f_r      = shift_q[R_W:1];
   assign f_p      = shift_q[R_W+1];
   assign f_a      = shift_q[A_W:1];
   assign f_n      = shift_q[A_W+N_W:A_W+1];
   assign len_ref  = (count_q == CNT_W'(REF_LEN));
   assign len_main = (count_q == CNT_W'(MAIN_LEN));
   assign r_ok     = (f_r >= R_W'(R_MIN));
   assign na_ok    = (f_n >= N_W'(N_MIN)) && (f_n >= N_W'(f_a));

   always_comb begin
      dst    = DST_NONE;
      reject = 1'b0;
      if (frame_end) begin
         if (len_ref && ctrl && r_ok)          dst = DST_REF;
         else if (len_main && !ctrl && na_ok)  dst = DST_MAIN;
         else                                  reject = 1'b1;
      end
   end
endmodule

// File: rtl/serial_div_prog.sv
module serial_div_prog
   import serial_div_prog_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int R_W         = 14,
   parameter int N_W         = 11,
   parameter int A_W         = 7,
   parameter int R_MIN       = 8,
   parameter int N_MIN       = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_strobe,
   output logic [R_W-1:0] r_div,
   output logic           presc_sel,
   output logic [N_W-1:0] n_div,
   output logic [A_W-1:0] a_div,
   output logic           r_upd,
   output logic           na_upd,
   output logic           prog_err
);
   localparam int REF_LEN  = R_W + 2;
   localparam int MAIN_LEN = N_W + A_W + 1;
   localparam int SR_W     = (REF_LEN > MAIN_LEN) ? REF_LEN : MAIN_LEN;
   localparam int CNT_MAX  = SR_W + 1;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("serial_div_prog: SYNC_STAGES must be at least 2");
      end
      if (REF_LEN == MAIN_LEN) begin : g_chk_len
         $error("serial_div_prog: word lengths must differ");
      end
      if (N_W < A_W) begin : g_chk_na
         $error("serial_div_prog: N_W must not be narrower than A_W");
      end
   endgenerate

   logic [2:0] sy;
   logic       sclk_q, stb_q, sclk_rise, stb_rise;

   sprog_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_in({ser_strobe, ser_data, ser_clk}),
      .d_out(sy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         stb_q  <= 1'b0;
      end else begin
         sclk_q <= sy[0];
         stb_q  <= sy[2];
      end
   end

   assign sclk_rise = sy[0] & ~sclk_q;
   assign stb_rise  = sy[2] & ~stb_q;

   logic [SR_W-1:0]  shift_q;
   logic [CNT_W-1:0] count_q;

   sprog_shifter #(.SR_W(SR_W), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .bit_en(sclk_rise), .bit_val(sy[1]), .frame_end(stb_rise),
      .shift_q(shift_q), .count_q(count_q)
   );

   dst_e           dst;
   logic           reject;
   logic [R_W-1:0] f_r;
   logic           f_p;
   logic [N_W-1:0] f_n;
   logic [A_W-1:0] f_a;

   sprog_decode #(
      .R_W(R_W), .N_W(N_W), .A_W(A_W), .R_MIN(R_MIN), .N_MIN(N_MIN),
      .SR_W(SR_W), .CNT_W(CNT_W)
   ) u_dec (
      .shift_q(shift_q), .count_q(count_q), .frame_end(stb_rise),
      .dst(dst), .reject(reject),
      .f_r(f_r), .f_p(f_p), .f_n(f_n), .f_a(f_a)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_div     <= '0;
         presc_sel <= 1'b0;
         n_div     <= '0;
         a_div     <= '0;
         r_upd     <= 1'b0;
         na_upd    <= 1'b0;
         prog_err  <= 1'b0;
      end else begin
         r_upd  <= (dst == DST_REF);
         na_upd <= (dst == DST_MAIN);
         if (dst == DST_REF) begin
            r_div     <= f_r;
            presc_sel <= f_p;
         end
         if (dst == DST_MAIN) begin
            n_div <= f_n;
            a_div <= f_a;
         end
         if (reject) prog_err <= 1'b1;
      end
   end
endmodule

// File: rtl/serial_div_prog_chk.sv
module serial_div_prog_chk #(
   parameter int R_W   = 14,
   parameter int N_W   = 11,
   parameter int A_W   = 7,
   parameter int R_MIN = 8,
   parameter int N_MIN = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic [R_W-1:0] r_div,
   input logic           presc_sel,
   input logic [N_W-1:0] n_div,
   input logic [A_W-1:0] a_div,
   input logic           r_upd,
   input logic           na_upd,
   input logic           prog_err
);
   p_r_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      r_upd |-> (r_div >= R_W'(R_MIN)));

   p_na_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      na_upd |-> ((n_div >= N_W'(N_MIN)) && (n_div >= N_W'(a_div))));

   p_ref_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !r_upd |-> ($stable(r_div) && $stable(presc_sel)));

   p_main_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !na_upd |-> ($stable(n_div) && $stable(a_div)));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      prog_err |=> prog_err);

   p_ref_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      r_upd |=> !r_upd);

   p_main_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      na_upd |=> !na_upd);

   p_one_dest_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({r_upd, na_upd}));
endmodule

bind serial_div_prog serial_div_prog_chk #(
   .R_W(R_W), .N_W(N_W), .A_W(A_W), .R_MIN(R_MIN), .N_MIN(N_MIN)
) u_chk (.*);

// File: tb/serial_div_prog_tb.sv
module serial_div_prog_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
   logic [13:0] r_div;
   logic        presc_sel;
   logic [10:0] n_div;
   logic [6:0]  a_div;
   logic        r_upd, na_upd, prog_err;

   always #2 clk = ~clk;

   serial_div_prog u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_strobe(ser_strobe), .r_div(r_div), .presc_sel(presc_sel),
      .n_div(n_div), .a_div(a_div), .r_upd(r_upd), .na_upd(na_upd),
      .prog_err(prog_err)
   );

   typedef struct {
      bit          is_ref;
      logic [13:0] r;
      logic        p;
      logic [10:0] n;
      logic [6:0]  a;
   } exp_t;

   exp_t q[$];
   exp_t mon_e;
   int   n_cmp = 0, n_bad = 0;
   bit   prev_r = 0, prev_na = 0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (r_upd || na_upd) begin
            if (q.size() == 0) begin
               check("R2", "unexpected update pulse", 1, 0);
            end else begin
               mon_e = q.pop_front();
               check("R12", "destination of pulse", {30'd0, r_upd, na_upd},
                     mon_e.is_ref ? 32'd2 : 32'd1);
               if (mon_e.is_ref) begin
                  check("R3", "r_div", 32'(r_div), 32'(mon_e.r));
                  check("R3", "presc_sel", 32'(presc_sel), 32'(mon_e.p));
               end else begin
                  check("R4", "n_div", 32'(n_div), 32'(mon_e.n));
                  check("R4", "a_div", 32'(a_div), 32'(mon_e.a));
               end
            end
            if ((r_upd && prev_r) || (na_upd && prev_na))
               check("R12", "pulse longer than one cycle", 1, 0);
         end
         prev_r  = r_upd;
         prev_na = na_upd;
      end else begin
         prev_r  = 0;
         prev_na = 0;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ser_clk = 1'b0; ser_data = 1'b0; ser_strobe = 1'b0;
      q.delete();
      tick(4);
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic shift_bits(logic [31:0] w, int len);
      for (int i = len - 1; i >= 0; i--) begin
         ser_data = w[i];
         tick(3);
         ser_clk = 1'b1;
         tick(3);
         ser_clk = 1'b0;
      end
      tick(3);
   endtask

   task automatic strobe();
      tick(2);
      ser_strobe = 1'b1;
      tick(3);
      ser_strobe = 1'b0;
      tick(8);
   endtask

   function automatic logic [31:0] ref_word(logic p, logic [13:0] r);
      return {16'd0, p, r, 1'b1};
   endfunction

   function automatic logic [31:0] main_word(logic [10:0] n, logic [6:0] a);
      return {13'd0, n, a, 1'b0};
   endfunction

   task automatic send_ref_ok(logic p, logic [13:0] r, string req);
      exp_t e;
      e.is_ref = 1; e.r = r; e.p = p; e.n = '0; e.a = '0;
      q.push_back(e);
      shift_bits(ref_word(p, r), 16);
      strobe();
      check(req, "reference update consumed", 32'(q.size()), 0);
   endtask

   task automatic send_main_ok(logic [10:0] n, logic [6:0] a, string req);
      exp_t e;
      e.is_ref = 0; e.r = '0; e.p = 1'b0; e.n = n; e.a = a;
      q.push_back(e);
      shift_bits(main_word(n, a), 19);
      strobe();
      check(req, "main update consumed", 32'(q.size()), 0);
   endtask

   task automatic expect_hold(string req, logic [13:0] r, logic p,
                              logic [10:0] n, logic [6:0] a);
      check(req, "r_div held", 32'(r_div), 32'(r));
      check(req, "presc_sel held", 32'(presc_sel), 32'(p));
      check(req, "n_div held", 32'(n_div), 32'(n));
      check(req, "a_div held", 32'(a_div), 32'(a));
      check(req, "error flag set", 32'(prog_err), 1);
   endtask

   bit done = 0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      rst_n = 1'b0;
      tick(3);
      check("R10", "r_div in reset", 32'(r_div), 0);
      check("R10", "pulses in reset", {30'd0, r_upd, na_upd}, 0);
      do_reset();
      check("R10", "r_div", 32'(r_div), 0);
      check("R10", "presc_sel", 32'(presc_sel), 0);
      check("R10", "n_div", 32'(n_div), 0);
      check("R10", "a_div", 32'(a_div), 0);
      check("R10", "prog_err", 32'(prog_err), 0);

      // R1 / R3: asymmetric reference value
      send_ref_ok(1'b1, 14'd100, "R3");
      check("R1", "MSB-first reference ratio", 32'(r_div), 100);

      // R2: bits shifted without strobe load nothing
      shift_bits(main_word(11'd500, 7'd37), 19);
      tick(10);
      check("R2", "n_div before strobe", 32'(n_div), 0);
      check("R2", "a_div before strobe", 32'(a_div), 0);
      begin
         exp_t e;
         e.is_ref = 0; e.r = '0; e.p = 1'b0; e.n = 11'd500; e.a = 7'd37;
         q.push_back(e);
      end
      strobe();
      check("R4", "main update after strobe", 32'(q.size()), 0);
      check("R4", "reference untouched by main word", 32'(r_div), 100);

      // R7 boundaries accepted, R3 prescaler bit both ways
      send_ref_ok(1'b0, 14'd8, "R7");
      send_ref_ok(1'b1, 14'd16383, "R7");

      // R8 boundaries accepted
      send_main_ok(11'd3, 7'd3, "R8");
      send_main_ok(11'd2047, 7'd127, "R8");
      send_main_ok(11'd1000, 7'd0, "R4");
      check("R9", "no error after valid frames", 32'(prog_err), 0);

      // R7: ratio below 8 rejected
      shift_bits(ref_word(1'b0, 14'd7), 16);
      strobe();
      expect_hold("R7", 14'd16383, 1'b1, 11'd1000, 7'd0);

      // R5: strobe with no bits
      do_reset();
      strobe();
      check("R5", "error after empty frame", 32'(prog_err), 1);

      // R5: 17-bit and 20-bit frames
      do_reset();
      send_ref_ok(1'b0, 14'd200, "R3");
      shift_bits({15'd0, 1'b0, ref_word(1'b0, 14'd300)}, 17);
      strobe();
      expect_hold("R5", 14'd200, 1'b0, 11'd0, 7'd0);
      shift_bits({12'd0, 1'b1, main_word(11'd600, 7'd9)}, 20);
      strobe();
      expect_hold("R5", 14'd200, 1'b0, 11'd0, 7'd0);

      // R6: control bit disagrees with length
      do_reset();
      send_main_ok(11'd77, 7'd11, "R4");
      shift_bits({16'd0, 1'b0, 14'd50, 1'b0}, 16);
      strobe();
      expect_hold("R6", 14'd0, 1'b0, 11'd77, 7'd11);
      do_reset();
      send_ref_ok(1'b1, 14'd900, "R3");
      shift_bits({13'd0, 11'd123, 7'd4, 1'b1}, 19);
      strobe();
      expect_hold("R6", 14'd900, 1'b1, 11'd0, 7'd0);

      // R8: main below swallow, main below 3
      do_reset();
      send_main_ok(11'd400, 7'd5, "R4");
      shift_bits(main_word(11'd10, 7'd20), 19);
      strobe();
      expect_hold("R8", 14'd0, 1'b0, 11'd400, 7'd5);
      shift_bits(main_word(11'd2, 7'd0), 19);
      strobe();
      expect_hold("R8", 14'd0, 1'b0, 11'd400, 7'd5);

      // R11: fresh frame after rejection accepted; R9: error stays
      send_ref_ok(1'b1, 14'd300, "R11");
      send_main_ok(11'd64, 7'd63, "R11");
      check("R9", "error kept after valid frames", 32'(prog_err), 1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule